// File: doc/BRIEF.md
# Programmable Dead-Time Insertion Unit

This block sits between a duty-cycle comparator and a pair of gate drivers. It takes one raw pulse-width-modulated signal and derives a high-side output (which follows the raw signal) and a low-side output (which follows its complement). On each output it then moves the switching edges by a programmable number of clock cycles.

A 2-bit mode code selects one of four treatments:

- **Positive dead time** delays turn-on, so the two switches are never on together.
- **Negative dead time** delays turn-off, which gives a deliberate overlap.
- **Disabled** passes the signals through without any delay.
- **Compensation** uses an external current-direction bit, combined with a polarity bit, to pick which output is shortened and which is lengthened.

There are two 14-bit delay values, a main one and an alternate one. The mode decides which output each value applies to.

Both outputs come from a single register stage clocked by the PWM clock. The delays count in whole clock cycles. A pulse too short to survive its delay is removed cleanly rather than producing a glitch.

Top module: `deadtime_unit`

## Requirements
- R1: While `rst_n` is low, both `pwm_hi` and `pwm_lo` are 0.
- R2: Mode code 2'b00 (positive) delays the rising edge of `pwm_hi` by `dly_main` cycles and the rising edge of `pwm_lo` by `dly_alt` cycles. Here `pwm_hi` follows `pwm_raw` and `pwm_lo` follows `!pwm_raw`, and falling edges take only the one register cycle.
- R3: In mode 2'b00, `pwm_hi` and `pwm_lo` are never 1 in the same cycle.
- R4: Mode code 2'b01 (negative) keeps `pwm_hi` high for `dly_alt` extra cycles after its falling edge, and keeps `pwm_lo` high for `dly_main` extra cycles after its falling edge. Rising edges take only the one register cycle.
- R5: When an output's turn-on is delayed by D cycles and its source level is high for D or fewer cycles, that output stays 0 for the whole pulse. When the source is high for K > D cycles, the output is high for K − D cycles.
- R6: In mode code 2'b10 (disabled), `pwm_hi` equals `pwm_raw` from the previous cycle and `pwm_lo` equals its complement. Both delay values have no effect.
- R7: In mode code 2'b11 (compensation) with `comp_dir ^ comp_pol` = 0, `pwm_hi` is shortened and `pwm_lo` is lengthened. The rising edge of `pwm_hi` is delayed by `dly_main`, and the falling edge of `pwm_lo` is extended by `dly_alt`.
- R8: In mode 2'b11 with `comp_dir ^ comp_pol` = 1, `pwm_lo` is shortened and `pwm_hi` is lengthened. The rising edge of `pwm_lo` is delayed by `dly_alt`, and the falling edge of `pwm_hi` is extended by `dly_main`.
- R9: Outside mode 2'b11, `comp_dir` and `comp_pol` have no effect on either output.
- R10: The delay counts are unsigned and 14 bits wide. A delay of 0 gives a plain one-cycle register delay, and counts into the tens of cycles are honoured exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_raw | input | 1 | Raw comparator output |
| mode | input | 2 | 00 positive, 01 negative, 10 disabled, 11 compensation |
| dly_main | input | 14 | Main delay count in clock cycles |
| dly_alt | input | 14 | Alternate delay count in clock cycles |
| comp_dir | input | 1 | Current-direction input for compensation |
| comp_pol | input | 1 | Inverts the sense of `comp_dir` |
| pwm_hi | output | 1 | High-side gate signal |
| pwm_lo | output | 1 | Low-side gate signal |

## Verification
The bound assertions check four things on every cycle:

- outputs never overlap in positive mode;
- both outputs track the raw signal exactly while the mode is disabled;
- a rising high side in positive mode is always preceded by a high raw input;
- a falling high side in negative mode always follows a low raw input.

The exact length of each delay, the removal of pulses that are too short, and the choice of shortened and lengthened output under each direction and polarity can only be shown by the bench. It runs a cycle model against the block over pulse trains of varied widths.

// File: rtl/deadtime_unit.sv
module deadtime_unit #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_raw,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] dly_main,
  input  logic [DW-1:0] dly_alt,
  input  logic          comp_dir,
  input  logic          comp_pol,
  output logic          pwm_hi,
  output logic          pwm_lo
);
  localparam logic [1:0]    M_POS = 2'b00;
  localparam logic [1:0]    M_NEG = 2'b01;
  localparam logic [1:0]    M_OFF = 2'b10;
  localparam logic [DW-1:0] SAT   = '1;
  localparam logic [DW-1:0] ZERO  = '0;

  logic          sense;
  logic [1:0]    want;
  logic [DW-1:0] rise_d [2];
  logic [DW-1:0] fall_d [2];

  assign sense = comp_dir ^ comp_pol;
  assign want  = {~pwm_raw, pwm_raw};

  // index 0 drives the high side, index 1 the low side
  always_comb begin
    rise_d[0] = ZERO; fall_d[0] = ZERO;
    rise_d[1] = ZERO; fall_d[1] = ZERO;
    case (mode)
      M_POS: begin rise_d[0] = dly_main; rise_d[1] = dly_alt;  end
      M_NEG: begin fall_d[0] = dly_alt;  fall_d[1] = dly_main; end
      M_OFF: ;
      default: begin
        if (sense) begin fall_d[0] = dly_main; rise_d[1] = dly_alt; end
        else       begin rise_d[0] = dly_main; fall_d[1] = dly_alt; end
      end
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : ch
    logic          lvl_q;
    logic [DW-1:0] run_q;
    logic [DW-1:0] held;
    logic          o_q;

    assign held = (want[g] == lvl_q) ? run_q : ZERO;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q <= 1'b0;
        run_q <= SAT;
        o_q   <= 1'b0;
      end else begin
        lvl_q <= want[g];
        run_q <= (held == SAT) ? SAT : held + 1'b1;
        o_q   <= want[g] ? (held >= rise_d[g]) : (held < fall_d[g]);
      end
    end
  end

  assign pwm_hi = ch[0].o_q;
  assign pwm_lo = ch[1].o_q;
endmodule

// File: rtl/deadtime_unit_chk.sv
module deadtime_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_raw,
  input logic [1:0] mode,
  input logic       pwm_hi,
  input logic       pwm_lo
);
  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b00) |-> !(pwm_hi && pwm_lo));

  // R6
  bypass_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b10 && $past(rst_n)) |->
      (pwm_hi == $past(pwm_raw) && pwm_lo == !$past(pwm_raw)));

  // R2
  pos_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwm_hi) && $past(mode) == 2'b00) |-> $past(pwm_raw));

  // R4
  neg_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm_hi) && $past(mode) == 2'b01) |-> !$past(pwm_raw));
endmodule

bind deadtime_unit deadtime_unit_chk u_chk (.*);

// File: tb/deadtime_unit_bench.sv
`timescale 1ns/1ps
module deadtime_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwm_raw = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [13:0] dly_main = 14'd3;
  logic [13:0] dly_alt = 14'd5;
  logic        comp_dir = 1'b0;
  logic        comp_pol = 1'b0;
  logic        pwm_hi, pwm_lo;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string req = "R1";

  always #10 clk = ~clk;

  deadtime_unit u_deadtime_unit (
    .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .mode(mode),
    .dly_main(dly_main), .dly_alt(dly_alt), .comp_dir(comp_dir),
    .comp_pol(comp_pol), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  // behavioural model: per output, the number of cycles its source level has held
  int  age [2];
  bit  lvl [2];
  bit  exp_o [2];

  task automatic model_step(input int k, input bit w, input int dr, input int df);
    int h;
    h = (w == lvl[k]) ? age[k] : 0;
    exp_o[k] = w ? (h >= dr) : (h < df);
    lvl[k] = w;
    age[k] = h + 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        age[k] = 1 << 20; lvl[k] = 1'b0; exp_o[k] = 1'b0;
      end
    end else begin
      int rh, fh, rl, fl;
      rh = 0; fh = 0; rl = 0; fl = 0;
      if (mode == 2'b00) begin rh = dly_main; rl = dly_alt; end
      else if (mode == 2'b01) begin fh = dly_alt; fl = dly_main; end
      else if (mode == 2'b11) begin
        if (comp_dir != comp_pol) begin fh = dly_main; rl = dly_alt; end
        else begin rh = dly_main; fl = dly_alt; end
      end
      model_step(0, pwm_raw, rh, fh);
      model_step(1, !pwm_raw, rl, fl);
    end
  end

  always @(negedge clk) begin
    cyc++;
    checks++;
    if (pwm_hi !== exp_o[0] || pwm_lo !== exp_o[1]) begin
      errors++;
      $display("FAIL %s cycle %0d: hi/lo actual %b%b expected %b%b",
               req, cyc, pwm_hi, pwm_lo, exp_o[0], exp_o[1]);
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic hold(input bit v, input int n);
    pwm_raw = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic train();
    hold(1, 1); hold(0, 1); hold(1, 2); hold(0, 8); hold(1, 3); hold(0, 3);
    hold(1, 4); hold(0, 4); hold(1, 6); hold(0, 10); hold(1, 20); hold(0, 2);
    hold(1, 9); hold(0, 5); hold(1, 5); hold(0, 6); hold(0, 20);
  endtask

  initial begin
    req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    req = "R2";  train();
    req = "R3";  dly_main = 14'd0; dly_alt = 14'd0; train();
    req = "R5";  dly_main = 14'd4; dly_alt = 14'd6; train();
    req = "R10"; dly_main = 14'd25; dly_alt = 14'd40; hold(1, 60); hold(0, 60); hold(1, 30); hold(0, 80);
    dly_main = 14'd3; dly_alt = 14'd5;
    req = "R9";  comp_pol = 1'b1; comp_dir = 1'b1; train(); comp_dir = 1'b0; train();
    mode = 2'b01;
    req = "R4";  comp_pol = 1'b0; train();
    req = "R9";  comp_dir = 1'b1; train();
    mode = 2'b10;
    req = "R6";  train(); comp_pol = 1'b1; dly_main = 14'd9; train();
    dly_main = 14'd3;
    mode = 2'b11;
    req = "R7";  comp_dir = 1'b0; comp_pol = 1'b0; train();
    req = "R7";  comp_dir = 1'b1; comp_pol = 1'b1; train();
    req = "R8";  comp_dir = 1'b1; comp_pol = 1'b0; train();
    req = "R8";  comp_dir = 1'b0; comp_pol = 1'b1; train();
    req = "R1";  rst_n = 1'b0; repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule